// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block reads a sixteen-key switch matrix through four row drive lines and four column sense lines. It raises one row line at a time and waits for the lines to settle before it reads the columns. If a column reads high, the key at that crossing is a candidate. The block waits a debounce interval, checks the same crossing again, and reports the key only if it is still pressed.

An accepted key appears as a code on `key_code_o` together with a pulse of one clock cycle on `key_valid_o`. The code is the row index times four plus the column index. The output stream has no back-pressure: the consumer must take the code in the cycle the pulse is high. While a key is held, the block drives all rows high and reports nothing more. Scanning starts again only after every column has read low for a full debounce interval. If several keys are down at once, the first one met in scan order is reported.

Both the scan rate and the debounce period are parameters counted in clock cycles.

Top module: `keypad_scanner`

## Requirements
- R1: Outside the held-key phase, exactly one row line is high. The row index steps 0, 1, 2, 3 and then wraps to 0. Each row stays active for SETTLE_CYC+2 cycles: the settle time plus two cycles of synchronizer latency. Reset selects row 0, so `row_o` = 4'b0001.
- R2: A high column line means that a key in the active row is pressed. The column lines pass through two flip-flops before any decision uses them.
- R3: If several columns in the active row are high, the lowest column index is taken.
- R4: The reported code is row*4 + column. Row 0 gives codes 0 to 3 and row 3 gives codes 12 to 15.
- R5: A candidate key is re-checked DEBOUNCE_CYC cycles after it is detected. It is reported only if its column is still high. The report is a single-cycle pulse on `key_valid_o`.
- R6: A candidate that fails the re-check is dropped without any report. Scanning then continues with the next row.
- R7: After a report, all four rows are driven high and no further key is reported. This lasts until the columns have read low for DEBOUNCE_CYC consecutive cycles. Scanning then restarts at row 0. A held key is therefore reported once, and a second key pressed while the first is held is not reported.
- R8: During reset, `key_valid_o` is 0, `key_code_o` is 0 and `row_o` is 4'b0001.
- R9: Contact bounce at press or at release that is shorter than the debounce interval still gives exactly one report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_i | input | 4 | Column sense lines, high when a key in the driven row is closed |
| row_o | output | 4 | Row drive lines, active high |
| key_code_o | output | 4 | Code of the accepted key |
| key_valid_o | output | 1 | One-cycle pulse marking a new code |

## Verification
The bench builds the block with SETTLE_CYC = 2 and DEBOUNCE_CYC = 20. A full scan then takes 16 cycles and a debounce window 20 cycles, so presses, glitches, bounce trains and long holds all fit within a few hundred cycles. A behavioural matrix model ORs each pressed key onto its column whenever its row is driven. This lets the bench exercise the scan-order choice within one row, rejection of short glitches, and suppression of a second key while the first is held, each against a queue of expected codes.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {
    KP_SCAN = 2'd0,
    KP_WAIT = 2'd1,
    KP_HOLD = 2'd2
  } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/kp_col_pick.sv
module kp_col_pick #(
  parameter int COLS  = 4,
  parameter int IDX_W = 2
) (
  input  logic [COLS-1:0]  cols_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // Walk from the top down so that the lowest high column is the last one assigned and wins.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (cols_i[c]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/kp_row_drive.sv
module kp_row_drive #(
  parameter int ROWS  = 4,
  parameter int ROW_W = 2
) (
  input  logic [ROW_W-1:0] sel_i,
  input  logic             all_i,
  output logic [ROWS-1:0]  rows_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rows_o[r] = all_i | (sel_i == ROW_W'(r));
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS         = 4,
  parameter int COLS         = 4,
  parameter int SETTLE_CYC   = 2,
  parameter int DEBOUNCE_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] col_i,
  output logic [3:0] row_o,
  output logic [3:0] key_code_o,
  output logic       key_valid_o
);
  import kp_pkg::*;

  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W     = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int CODE_W    = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1;
  localparam int SAMPLE_AT = SETTLE_CYC + 1;
  localparam int DB_LAST   = DEBOUNCE_CYC - 1;
  localparam int CNT_MAX   = (SAMPLE_AT > DB_LAST) ? SAMPLE_AT : DB_LAST;
  localparam int CNT_W     = $clog2(CNT_MAX + 1) + 1;

  kp_state_e        state_q;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_next;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] cnt_q;
  logic [COLS-1:0]  col_s;
  logic             pick_found;
  logic [COL_W-1:0] pick_idx;
  logic [ROWS-1:0]  rows_drv;
  logic [CODE_W-1:0] code_q;
  logic             valid_q;

  kp_sync #(.W(COLS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (col_i[COLS-1:0]),
    .q_o   (col_s)
  );

  kp_col_pick #(.COLS(COLS), .IDX_W(COL_W)) u_pick (
    .cols_i  (col_s),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  kp_row_drive #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .sel_i  (row_q),
    .all_i  (state_q == KP_HOLD),
    .rows_o (rows_drv)
  );

  assign row_next = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KP_SCAN;
      row_q   <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        KP_SCAN: begin
          if (cnt_q == CNT_W'(SAMPLE_AT)) begin
            cnt_q <= '0;
            if (pick_found) begin
              col_q   <= pick_idx;
              state_q <= KP_WAIT;
            end else begin
              row_q <= row_next;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        KP_WAIT: begin
          if (cnt_q == CNT_W'(DB_LAST)) begin
            cnt_q <= '0;
            if (col_s[col_q]) begin
              valid_q <= 1'b1;
              code_q  <= CODE_W'(row_q) * CODE_W'(COLS) + CODE_W'(col_q);
              state_q <= KP_HOLD;
            end else begin
              row_q   <= row_next;
              state_q <= KP_SCAN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        KP_HOLD: begin
          if (|col_s) begin
            cnt_q <= '0;
          end else if (cnt_q == CNT_W'(DB_LAST)) begin
            cnt_q   <= '0;
            row_q   <= '0;
            state_q <= KP_SCAN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= KP_SCAN;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign row_o       = 4'(rows_drv);
  assign key_code_o  = 4'(code_q);
  assign key_valid_o = valid_q;

  logic [3:0] row_rot;
  assign row_rot = {row_o[2:0], row_o[3]};

  // R1: while scanning, a change of row moves to the next row in order.
  a_r1_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KP_SCAN && $past(state_q) == KP_SCAN && row_o != $past(row_o))
      |-> row_o == $past(row_rot));

  // R5: a report lasts exactly one cycle.
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |=> !key_valid_o);

  // R5: the wait counter never runs past its window.
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

  // R7: all rows are driven while a key is held.
  a_r7_all_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KP_HOLD) |-> (&row_o));

  // R7: nothing new is reported during the hold phase.
  a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KP_HOLD && $past(state_q) == KP_HOLD) |-> !key_valid_o);
endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 2;
  localparam int DB         = 20;
  localparam int ROW_HOLD   = SETTLE + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] keys = '0;
  logic [3:0] col;
  logic [3:0] row;
  logic [3:0] code;
  logic       valid;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Matrix model: a pressed key ties its row line to its column line.
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col[c] = 1'b0;
      for (int r = 0; r < 4; r++) col[c] = col[c] | (row[r] & keys[r * 4 + c]);
    end
  end

  keypad_scanner #(
    .ROWS(4), .COLS(4), .SETTLE_CYC(SETTLE), .DEBOUNCE_CYC(DB)
  ) u_keypad_scanner (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_i       (col),
    .row_o       (row),
    .key_code_o  (code),
    .key_valid_o (valid)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on every reported key.
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && valid) begin
      check(!prev_valid, "R5 pulse longer than one cycle", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected report", int'(code), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(code) == e, "R4 key code", int'(code), e);
      end
    end
    prev_valid = rst_n & valid;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic tap(int k, int hold);
    exp_q.push_back(k);
    keys[k] = 1'b1;
    wait_cyc(hold);
    keys[k] = 1'b0;
    wait_cyc(80);
  endtask

  initial begin
    wait_cyc(3);
    // R8: reset values
    check(row == 4'b0001, "R8 row in reset", int'(row), 1);
    check(valid == 1'b0, "R8 valid in reset", int'(valid), 0);
    check(code == 4'd0, "R8 code in reset", int'(code), 0);
    rst_n = 1'b1;

    // R1: scan order, each row held ROW_HOLD cycles
    wait_cyc(1);
    for (int i = 0; i < 5; i++) begin
      check(row == 4'(1 << (i % 4)), "R1 row sequence", int'(row), 1 << (i % 4));
      wait_cyc(ROW_HOLD);
    end

    // R4 / R2: codes across the matrix
    tap(0, 100);  drained("R4 code 0 reported");
    tap(15, 100); drained("R4 code 15 reported");
    tap(10, 100); drained("R4 code 10 reported");

    // R7: long hold reports once
    tap(5, 300);  drained("R7 held key once");

    // R6: short glitch gives no report
    keys[3] = 1'b1;
    wait_cyc(10);
    keys[3] = 1'b0;
    wait_cyc(80);
    drained("R6 glitch rejected");

    // R3: two keys in one row, lowest column wins
    exp_q.push_back(6);
    keys[6] = 1'b1; keys[7] = 1'b1;
    wait_cyc(100);
    keys[6] = 1'b0; keys[7] = 1'b0;
    wait_cyc(80);
    drained("R3 lowest column");

    // R7: second key while first held is not reported
    exp_q.push_back(5);
    keys[5] = 1'b1;
    wait_cyc(100);
    keys[8] = 1'b1;
    wait_cyc(100);
    keys[5] = 1'b0;
    wait_cyc(5);
    keys[8] = 1'b0;
    wait_cyc(80);
    drained("R7 second key suppressed");

    // R9: bounce at press and release gives one report
    exp_q.push_back(12);
    for (int i = 0; i < 6; i++) begin
      keys[12] = ~keys[12];
      wait_cyc(2);
    end
    keys[12] = 1'b1;
    wait_cyc(100);
    for (int i = 0; i < 6; i++) begin
      keys[12] = ~keys[12];
      wait_cyc(2);
    end
    keys[12] = 1'b0;
    wait_cyc(100);
    drained("R9 bounce single report");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule